// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block holds a small table of programmable windows. Each window maps a naturally aligned, power-of-two region of the outbound (CPU side) address space onto a region of the link-side address space. A hit also tags the request as either a memory or an I/O transaction. Each window is programmed through five 32-bit words on a simple register bus:

- a 64-bit source base, whose low word also carries an enable bit and a size code;
- a 64-bit translated base;
- a parameter word that holds the window type and the transaction type.

A request is an address qualified by a valid strobe. One clock later the block returns the outcome. On a hit it gives the translated address, the transaction type, the window type and the index of the winning window. On a miss it raises a miss indication and drives all translation fields to zero, so that nothing downstream forwards the request.

Top module: `obx_xlate_table`

## Requirements
- R1: After reset every stored word reads as zero, every window is disabled, `rsp_valid_o` is low, and any request misses.
- R2: Window n occupies register addresses 0x800 + 0x20·n. Its words sit at these offsets:
  - +0x00: source low word
  - +0x04: source high word
  - +0x08: translated low word
  - +0x0C: translated high word
  - +0x10: parameter word

  Words written at these offsets read back unchanged. Any other address in 0x800–0x8FF, any address outside that range, and any address that is not word aligned reads as zero, and a write to it changes no stored word.
- R3: Bit 0 of the source low word enables the window. A window with bit 0 clear never matches.
- R4: Bits 6:1 of the source low word hold k−1, where the window spans 2^k bytes (k from 1 to 64). A request matches when its address bits 63:k equal those bits of the source base. Source base bits 6:0 count as zero in this comparison.
- R5: On a hit, address bits k−1:0 come from the request and bits 63:k come from the translated base. Translated base bits below k have no effect.
- R6: Parameter bits 3:0 are the window type and bits 18:16 are the transaction type (0 = memory, 2 = I/O). A hit reports both fields. All other parameter bits read back as zero.
- R7: When several enabled windows match, the lowest-numbered window is used, and its index appears on `rsp_win_o`.
- R8: On a miss, `rsp_hit_o` is 0 and `rsp_addr_o`, `rsp_win_o`, `rsp_tlp_type_o` and `rsp_win_type_o` are all 0.
- R9: `rsp_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high. While it is low, `rsp_hit_o` and all response fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| req_valid_i | input | 1 | Outbound request valid |
| req_addr_i | input | 64 | Outbound request address |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_hit_o | output | 1 | 1 = translated, 0 = miss |
| rsp_win_o | output | 3 | Index of the winning window |
| rsp_addr_o | output | 64 | Translated link-side address |
| rsp_win_type_o | output | 4 | Window type of the winning window |
| rsp_tlp_type_o | output | 3 | Transaction type of the winning window |

## Verification
A corrupted stored word shows up at the ports in one of two ways. It appears at once on `reg_rdata_o` when that word is addressed. Otherwise it appears one cycle after the next request whose address falls near the affected window, as a wrong hit, a wrong upper address or a wrong type. A wrong size decode or a wrong priority choice only shows for addresses close to a window edge or inside overlapping windows. For that reason the random requests are aimed at offsets just inside and just outside the programmed windows, and overlaps are built on purpose. A fault in the response register shows one cycle after any request, as a valid strobe or miss fields that do not match the request.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int XLT_AW     = 64;
  localparam int XLT_WIN_SH = 5;  // 32-byte register stride per window

  localparam logic [4:0] OFF_SRC_LO = 5'h00;
  localparam logic [4:0] OFF_SRC_HI = 5'h04;
  localparam logic [4:0] OFF_TRL_LO = 5'h08;
  localparam logic [4:0] OFF_TRL_HI = 5'h0C;
  localparam logic [4:0] OFF_PARAM  = 5'h10;

  typedef struct packed {
    logic [31:0] src_lo;
    logic [31:0] src_hi;
    logic [31:0] trl_lo;
    logic [31:0] trl_hi;
    logic [3:0]  win_type;
    logic [2:0]  tlp_type;
  } xlt_win_t;
endpackage

// File: rtl/xlt_regs.sv
module xlt_regs
  import xlt_pkg::*;
#(
  parameter int                NUM_WIN  = 8,
  parameter int                REG_AW   = 12,
  parameter logic [REG_AW-1:0] REG_BASE = 12'h800,
  localparam int               WIN_BITS = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output xlt_win_t          win_o [NUM_WIN]
);
  localparam logic [REG_AW-1:0] SPAN = REG_AW'(NUM_WIN << XLT_WIN_SH);

  logic [REG_AW-1:0]   rel;
  logic                in_rng;
  logic [WIN_BITS-1:0] widx;
  logic [4:0]          off;
  xlt_win_t            win_q [NUM_WIN];

  assign rel    = addr_i - REG_BASE;
  assign in_rng = (addr_i >= REG_BASE) && (rel < SPAN) && (addr_i[1:0] == 2'b00);
  assign widx   = rel[XLT_WIN_SH+WIN_BITS-1:XLT_WIN_SH];
  assign off    = rel[4:0];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_q[g] <= '0;
      end else if (wr_en_i && in_rng && widx == WIN_BITS'(g)) begin
        case (off)
          OFF_SRC_LO: win_q[g].src_lo <= wdata_i;
          OFF_SRC_HI: win_q[g].src_hi <= wdata_i;
          OFF_TRL_LO: win_q[g].trl_lo <= wdata_i;
          OFF_TRL_HI: win_q[g].trl_hi <= wdata_i;
          OFF_PARAM: begin
            win_q[g].win_type <= wdata_i[3:0];
            win_q[g].tlp_type <= wdata_i[18:16];
          end
          default: ;
        endcase
      end
    end
    assign win_o[g] = win_q[g];
  end

  always_comb begin
    rdata_o = '0;
    if (in_rng) begin
      case (off)
        OFF_SRC_LO: rdata_o = win_q[widx].src_lo;
        OFF_SRC_HI: rdata_o = win_q[widx].src_hi;
        OFF_TRL_LO: rdata_o = win_q[widx].trl_lo;
        OFF_TRL_HI: rdata_o = win_q[widx].trl_hi;
        OFF_PARAM:  rdata_o = {13'b0, win_q[widx].tlp_type, 12'b0, win_q[widx].win_type};
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/xlt_match.sv
module xlt_match
  import xlt_pkg::*;
(
  input  logic [31:0]       src_lo_i,
  input  logic [31:0]       src_hi_i,
  input  logic [XLT_AW-1:0] trl_i,
  input  logic [XLT_AW-1:0] addr_i,
  output logic              hit_o,
  output logic [XLT_AW-1:0] xaddr_o
);
  logic [6:0]        log2_sz;
  logic [XLT_AW-1:0] low_mask;
  logic [XLT_AW-1:0] src_base;

  assign log2_sz  = {1'b0, src_lo_i[6:1]} + 7'd1;  // 1..64
  assign low_mask = {XLT_AW{1'b1}} >> (7'd64 - log2_sz);
  assign src_base = {src_hi_i, src_lo_i[31:7], 7'b0};
  assign hit_o    = src_lo_i[0] && (((addr_i ^ src_base) & ~low_mask) == '0);
  assign xaddr_o  = (trl_i & ~low_mask) | (addr_i & low_mask);
endmodule

// File: rtl/xlt_prio.sv
module xlt_prio #(
  parameter  int NUM_WIN  = 8,
  localparam int WIN_BITS = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0]  hit_i,
  output logic                any_o,
  output logic [WIN_BITS-1:0] sel_o
);
  always_comb begin
    sel_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_i[i]) sel_o = WIN_BITS'(i);
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/obx_xlate_table.sv
module obx_xlate_table
  import xlt_pkg::*;
#(
  parameter  int                NUM_WIN  = 8,
  parameter  int                REG_AW   = 12,
  parameter  logic [REG_AW-1:0] REG_BASE = 12'h800,
  localparam int                WIN_BITS = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  input  logic                req_valid_i,
  input  logic [XLT_AW-1:0]   req_addr_i,
  output logic                rsp_valid_o,
  output logic                rsp_hit_o,
  output logic [WIN_BITS-1:0] rsp_win_o,
  output logic [XLT_AW-1:0]   rsp_addr_o,
  output logic [3:0]          rsp_win_type_o,
  output logic [2:0]          rsp_tlp_type_o
);
  xlt_win_t            win [NUM_WIN];
  logic [NUM_WIN-1:0]  hit;
  logic [XLT_AW-1:0]   xaddr [NUM_WIN];
  logic                any_hit;
  logic [WIN_BITS-1:0] sel;

  xlt_regs #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .REG_BASE(REG_BASE)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .win_o   (win)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
    xlt_match u_match (
      .src_lo_i (win[g].src_lo),
      .src_hi_i (win[g].src_hi),
      .trl_i    ({win[g].trl_hi, win[g].trl_lo}),
      .addr_i   (req_addr_i),
      .hit_o    (hit[g]),
      .xaddr_o  (xaddr[g])
    );
  end

  xlt_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .hit_i (hit),
    .any_o (any_hit),
    .sel_o (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_hit_o      <= 1'b0;
      rsp_win_o      <= '0;
      rsp_addr_o     <= '0;
      rsp_win_type_o <= '0;
      rsp_tlp_type_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i && any_hit) begin
        rsp_hit_o      <= 1'b1;
        rsp_win_o      <= sel;
        rsp_addr_o     <= xaddr[sel];
        rsp_win_type_o <= win[sel].win_type;
        rsp_tlp_type_o <= win[sel].tlp_type;
      end else begin
        rsp_hit_o      <= 1'b0;
        rsp_win_o      <= '0;
        rsp_addr_o     <= '0;
        rsp_win_type_o <= '0;
        rsp_tlp_type_o <= '0;
      end
    end
  end
endmodule

// File: rtl/xlt_table_chk.sv
module xlt_table_chk #(
  parameter  int NUM_WIN  = 8,
  localparam int WIN_BITS = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic [63:0]         req_addr_i,
  input logic                rsp_valid_o,
  input logic                rsp_hit_o,
  input logic [WIN_BITS-1:0] rsp_win_o,
  input logic [63:0]         rsp_addr_o,
  input logic [3:0]          rsp_win_type_o,
  input logic [2:0]          rsp_tlp_type_o
);
  p_valid_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  p_no_hit_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_hit_o);

  p_miss_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |->
      (rsp_addr_o == '0 && rsp_win_o == '0 && rsp_tlp_type_o == '0 && rsp_win_type_o == '0));

  // the smallest window is 2 bytes, so bit 0 always comes from the request
  p_offset_bit0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!rsp_hit_o || rsp_addr_o[0] == $past(req_addr_i[0])));
endmodule

bind obx_xlate_table xlt_table_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_addr_i     (req_addr_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_hit_o      (rsp_hit_o),
  .rsp_win_o      (rsp_win_o),
  .rsp_addr_o     (rsp_addr_o),
  .rsp_win_type_o (rsp_win_type_o),
  .rsp_tlp_type_o (rsp_tlp_type_o)
);

// File: tb/obx_xlate_table_bench.sv
module obx_xlate_table_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [63:0] req_addr_i = '0;
  logic        rsp_valid_o, rsp_hit_o;
  logic [2:0]  rsp_win_o;
  logic [63:0] rsp_addr_o;
  logic [3:0]  rsp_win_type_o;
  logic [2:0]  rsp_tlp_type_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_slo [8];
  logic [31:0] m_shi [8];
  logic [31:0] m_tlo [8];
  logic [31:0] m_thi [8];
  logic [31:0] m_par [8];

  always #2 clk_i = ~clk_i;

  obx_xlate_table u_obx_xlate_table (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] wa(input int w, input int off);
    return 12'(12'h800 + w * 32 + off);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    if (a >= 12'h800 && a < 12'h900 && a[1:0] == 2'b00) begin
      case (a[4:0])
        5'h00: m_slo[a[7:5]] = d;
        5'h04: m_shi[a[7:5]] = d;
        5'h08: m_tlo[a[7:5]] = d;
        5'h0C: m_thi[a[7:5]] = d;
        5'h10: m_par[a[7:5]] = d & 32'h0007_000F;
        default: ;
      endcase
    end
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    reg_addr_i = a;
    #1;
    chk(tag, 64'(reg_rdata_o), 64'(exp));
  endtask

  task automatic prog(input int w, input logic [63:0] src, input int k, input logic [63:0] trl,
                      input logic [31:0] par, input bit en);
    wr(wa(w, 0), {src[31:7], 6'(k - 1), en});
    wr(wa(w, 4), src[63:32]);
    wr(wa(w, 8), trl[31:0]);
    wr(wa(w, 12), trl[63:32]);
    wr(wa(w, 16), par);
  endtask

  // reference model: lowest enabled window whose upper bits match
  task automatic model(input logic [63:0] a, output bit hit, output logic [2:0] idx,
                       output logic [63:0] xa, output logic [3:0] wt, output logic [2:0] tt);
    hit = 0; idx = 0; xa = 0; wt = 0; tt = 0;
    for (int i = 0; i < 8; i++) begin
      if (!hit && m_slo[i][0]) begin
        int k;
        logic [63:0] lm, sb;
        k  = int'(m_slo[i][6:1]) + 1;
        lm = (k == 64) ? '1 : ((64'd1 << k) - 64'd1);
        sb = {m_shi[i], m_slo[i][31:7], 7'b0};
        if (((a ^ sb) & ~lm) == 0) begin
          hit = 1; idx = 3'(i);
          xa  = ({m_thi[i], m_tlo[i]} & ~lm) | (a & lm);
          wt  = m_par[i][3:0]; tt = m_par[i][18:16];
        end
      end
    end
  endtask

  task automatic req(input string tag, input logic [63:0] a);
    bit h; logic [2:0] ix; logic [63:0] xa; logic [3:0] wt; logic [2:0] tt;
    model(a, h, ix, xa, wt, tt);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({tag, " valid R9"}, 64'(rsp_valid_o), 64'd1);
    chk({tag, " hit R3 R4 R8"}, 64'(rsp_hit_o), 64'(h));
    chk({tag, " win R7"}, 64'(rsp_win_o), 64'(ix));
    chk({tag, " addr R5"}, rsp_addr_o, xa);
    chk({tag, " types R6"}, 64'({rsp_win_type_o, rsp_tlp_type_o}), 64'({wt, tt}));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_slo[i] = 0; m_shi[i] = 0; m_tlo[i] = 0; m_thi[i] = 0; m_par[i] = 0;
    end
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 rsp_valid after reset", 64'(rsp_valid_o), 64'd0);
    rd("R1 src_lo w0", wa(0, 0), 32'h0);
    rd("R1 param w7", wa(7, 16), 32'h0);
    req("R1 miss after reset", 64'h0);

    // R2 register map and readback
    wr(wa(3, 0), 32'hDEAD_BEE0);
    wr(wa(3, 4), 32'h1234_5678);
    wr(wa(3, 8), 32'hCAFE_F00D);
    wr(wa(3, 12), 32'h0BAD_C0DE);
    rd("R2 src_lo w3", wa(3, 0), 32'hDEAD_BEE0);
    rd("R2 src_hi w3", wa(3, 4), 32'h1234_5678);
    rd("R2 trl_lo w3", wa(3, 8), 32'hCAFE_F00D);
    rd("R2 trl_hi w3", wa(3, 12), 32'h0BAD_C0DE);
    wr(wa(3, 24), 32'hFFFF_FFFF);
    rd("R2 unmapped offset", wa(3, 24), 32'h0);
    rd("R2 out of range", 12'h900, 32'h0);
    wr(12'h801, 32'h0000_00FF);
    rd("R2 misaligned write ignored", wa(0, 0), 32'h0);
    wr(wa(3, 0), 32'h0);

    // R6 parameter masking
    wr(wa(5, 16), 32'hFFFF_FFFF);
    rd("R6 param mask", wa(5, 16), 32'h0007_000F);
    wr(wa(5, 16), 32'h0);

    // R3 disabled window
    prog(0, 64'h0000_0001_0000_2000, 12, 64'h0000_00AA_0000_0000, 32'h0002_0001, 1'b0);
    req("R3 disabled window", 64'h0000_0001_0000_2345);
    // R4 size edges, 4 KiB window
    prog(0, 64'h0000_0001_0000_2000, 12, 64'h0000_00AA_0000_0FFF, 32'h0002_0001, 1'b1);
    req("R4 window start", 64'h0000_0001_0000_2000);
    req("R4 window last byte", 64'h0000_0001_0000_2FFF);
    req("R4 just above", 64'h0000_0001_0000_3000);
    req("R4 just below", 64'h0000_0001_0000_1FFF);
    // R5 translated low bits ignored (trl base has 0xFFF set)
    req("R5 offset carry", 64'h0000_0001_0000_2ABC);
    // R4 smallest window: source bits 6:0 count as zero
    prog(4, 64'h0000_0000_0000_5000, 1, 64'h0000_0000_7777_0000, 32'h0000_0000, 1'b1);
    req("R4 2-byte window hit", 64'h0000_0000_0000_5001);
    req("R4 2-byte window miss", 64'h0000_0000_0000_5002);

    // R7 overlap: window 2 (64 KiB) and window 1 (1 MiB) both cover, window 1 wins
    prog(2, 64'h0000_0001_0000_0000, 16, 64'h0000_0022_0000_0000, 32'h0000_0001, 1'b1);
    prog(1, 64'h0000_0001_0000_0000, 20, 64'h0000_0011_0000_0000, 32'h0002_0001, 1'b1);
    req("R7 lowest wins", 64'h0000_0001_0000_0100);
    wr(wa(1, 0), 32'h0);
    req("R7 next window", 64'h0000_0001_0000_0100);

    // R4 full 64-bit window on window 7 catches everything else
    prog(7, 64'h0, 64, 64'h0, 32'h0000_0003, 1'b1);
    req("R4 full-size window", 64'hFEDC_BA98_7654_3210);
    wr(wa(7, 0), 32'h0);
    req("R8 miss after disable", 64'hFEDC_BA98_7654_3210);

    // R9 idle cycle
    @(negedge clk_i);
    chk("R9 idle no valid", 64'(rsp_valid_o), 64'd0);
    chk("R9 idle no hit", 64'(rsp_hit_o), 64'd0);

    // random windows and near-edge requests
    for (int it = 0; it < 400; it++) begin
      if (it % 20 == 0) begin
        int w, k;
        logic [63:0] sb, tb;
        w  = int'($urandom % 8);
        k  = 1 + int'($urandom % 24);
        sb = {30'b0, 2'($urandom), $urandom};
        tb = {$urandom, $urandom};
        prog(w, sb, k, tb, ($urandom % 2) ? 32'h0002_0001 : 32'h0000_0000, 1'($urandom % 4 != 0));
      end
      begin
        int w;
        logic [63:0] a;
        w = int'($urandom % 8);
        a = {m_shi[w], m_slo[w][31:7], 7'b0};
        case ($urandom % 4)
          0: a = a ^ 64'($urandom % 64);
          1: a = a ^ (64'd1 << ($urandom % 26));
          2: a = a - 64'd1;
          default: a = {30'b0, 2'($urandom), $urandom};
        endcase
        req("rand R4 R5 R7", a);
      end
    end
    finish_run();
  end
endmodule